// File: doc/BRIEF.md
# Nametable Quadrant Mapper with Internal RAM

This block sits between the picture processor's nametable address space and its possible backing stores. That space is split into four 1 KB quadrants. Each quadrant has its own 2-bit selector. The selector picks one of four sources:

- one of the two console-side nametable pages,
- a 1 KB RAM held inside the block,
- a fill source that returns one programmed tile byte and one programmed attribute pattern.

For the console pages, the block drives a select strobe and a page bit to the console's own memory. For the internal sources, the block returns the data itself on its own data path.

The same 1 KB RAM has a second port facing the CPU, mapped at $5C00-$5FFF. A 2-bit mode register decides what the CPU may do with it:

- In modes 0 and 1 the RAM serves as nametable memory. CPU writes land only while rendering is in progress, and CPU reads see zero.
- In mode 2 the RAM is ordinary read/write CPU memory.
- In mode 3 the RAM is read-only to the CPU.

The fill tile and the fill attribute come from two further registers, at $5106 and $5107.

Top module: `nt_quad_mapper`

## Requirements
- R1: After reset the mode, mapping, fill tile and fill attribute registers are all zero, and `cpuRdData`, `ppuRdData` and `ppuDataOe` are zero.
- R2: A CPU write to $5104 stores only bits 1:0 as the mode. Bits 7:2 of the written byte are ignored.
- R3: A CPU write to $5105 stores the mapping byte. Quadrant q is given by picture address bits 11:10 (0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right). Its source is taken from mapping bits 2q+1:2q.
- R4: For a nametable address (bit 13 set and not $3F00-$3FFF), the selected source decides two outputs. With source 0 or 1, `conNtSel` is 1 in the same cycle and `conNtPage` equals the source value. Writing $44 to $5105 therefore gives pages 0,1,0,1 across quadrants 0..3.
- R5: A `ppuRd` to a quadrant with source 2 sets `ppuDataOe` one cycle later. In modes 0 and 1, `ppuRdData` then carries the RAM byte at address bits 9:0. In modes 2 and 3, `ppuRdData` is zero.
- R6: A `ppuRd` to a quadrant with source 3 sets `ppuDataOe` one cycle later. If offset bits 9:0 are below $3C0, `ppuRdData` is the fill tile register ($5106). Otherwise it is the fill attribute ($5107, bits 1:0) copied into all four 2-bit fields.
- R7: In mode 2 a CPU write to $5C00-$5FFF stores the byte at offset address-$5C00. A CPU read there returns the stored byte on `cpuRdData` one cycle later.
- R8: In modes 0 and 1, a CPU write to the RAM window is stored only while `rendering` is 1, and a CPU read returns zero.
- R9: In mode 3 a CPU read of the RAM window returns the stored byte, and CPU writes are ignored.
- R10: A picture address outside $2000-$3EFF gives `conNtSel` 0, and one cycle later `ppuDataOe` 0 and `ppuRdData` 0.
- R11: If a picture read and a CPU write hit the same RAM offset in the same cycle, the picture read returns the byte held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWe | input | 1 | CPU write strobe, one cycle |
| cpuRe | input | 1 | CPU read strobe, one cycle |
| cpuRdData | output | 8 | CPU read data, one cycle after `cpuRe` |
| rendering | input | 1 | High while the picture processor is rendering |
| ppuAddr | input | 14 | Picture processor address |
| ppuRd | input | 1 | Picture processor read strobe |
| ppuRdData | output | 8 | Data from the internal RAM or fill source |
| ppuDataOe | output | 1 | High when `ppuRdData` is driven by the block |
| conNtSel | output | 1 | Selects the console nametable memory |
| conNtPage | output | 1 | Console nametable page bit |

## Verification
`conNtSel` and `conNtPage` are combinational, so the bench compares them 1 ns after driving the picture address, before the next edge. Register writes and RAM writes take effect at the next edge. `cpuRdData`, `ppuRdData` and `ppuDataOe` are registered, so each one is compared at the falling edge that follows the edge capturing the request. The behavioural model predicts every result from its state before that edge, which also covers the read-before-write case of R11. RAM bytes the model has never written are excluded from data comparison.

// File: rtl/nt_map_pkg.sv
package nt_map_pkg;
  localparam logic [15:0] MODE_ADDR      = 16'h5104;
  localparam logic [15:0] MAP_ADDR       = 16'h5105;
  localparam logic [15:0] FILL_TILE_ADDR = 16'h5106;
  localparam logic [15:0] FILL_ATTR_ADDR = 16'h5107;
  localparam logic [15:0] RAM_BASE       = 16'h5C00;
  localparam logic [9:0]  ATTR_START     = 10'h3C0;

  typedef enum logic [1:0] {
    SRC_PAGE_A = 2'd0,
    SRC_PAGE_B = 2'd1,
    SRC_RAM    = 2'd2,
    SRC_FILL   = 2'd3
  } ntSrcE;

  typedef struct packed {
    logic ramWr;      // store CPU byte into internal RAM
    logic cpuRamRd;   // CPU read served from RAM
    logic ppuOwn;     // picture read answered by this block
    logic ppuRamRd;   // picture read served from RAM
    logic ppuFillRd;  // picture read served from fill source
    logic fillAttrRd; // fill read falls in the attribute area
  } ntStrobeT;
endpackage

// File: rtl/nt_map_ctrl.sv
module nt_map_ctrl
  import nt_map_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  input  logic        cpuWe,
  input  logic        cpuRe,
  input  logic        rendering,
  input  logic [13:0] ppuAddr,
  input  logic        ppuRd,
  output ntStrobeT    strb,
  output logic        conNtSel,
  output logic        conNtPage,
  output logic [7:0]  fillTile,
  output logic [1:0]  fillAttr
);
  logic [1:0] modeReg;
  logic [7:0] mapReg;
  logic       cpuInWin;
  logic       ppuInNt;
  logic [1:0] quad;
  ntSrcE      src;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= '0;
      mapReg   <= '0;
      fillTile <= '0;
      fillAttr <= '0;
    end else if (cpuWe) begin
      case (cpuAddr)
        MODE_ADDR:      modeReg  <= cpuWrData[1:0];
        MAP_ADDR:       mapReg   <= cpuWrData;
        FILL_TILE_ADDR: fillTile <= cpuWrData;
        FILL_ATTR_ADDR: fillAttr <= cpuWrData[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cpuInWin  = (cpuAddr[15:RAM_AW] == RAM_BASE[15:RAM_AW]);
    ppuInNt   = ppuAddr[13] && (ppuAddr[13:8] != 6'h3F);
    quad      = ppuAddr[11:10];
    src       = ntSrcE'(mapReg[{quad, 1'b0} +: 2]);
    conNtSel  = ppuInNt && (src == SRC_PAGE_A || src == SRC_PAGE_B);
    conNtPage = conNtSel && (src == SRC_PAGE_B);

    strb.ramWr      = cpuWe && cpuInWin &&
                      ((modeReg == 2'd2) || (!modeReg[1] && rendering));
    strb.cpuRamRd   = cpuRe && cpuInWin && modeReg[1];
    strb.ppuOwn     = ppuRd && ppuInNt && src[1];
    strb.ppuRamRd   = strb.ppuOwn && (src == SRC_RAM) && !modeReg[1];
    strb.ppuFillRd  = strb.ppuOwn && (src == SRC_FILL);
    strb.fillAttrRd = (ppuAddr[9:0] >= ATTR_START);
  end

  // R2
  mode_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeReg) |-> $past(cpuWe && cpuAddr == MODE_ADDR));
  // R9
  ro_mode_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == 2'd3) |-> !strb.ramWr);
  // R4
  one_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({conNtSel && ppuRd, strb.ppuRamRd, strb.ppuFillRd}));
endmodule

// File: rtl/nt_map_datapath.sv
module nt_map_datapath
  import nt_map_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ntStrobeT          strb,
  input  logic [RAM_AW-1:0] cpuOff,
  input  logic [RAM_AW-1:0] ppuOff,
  input  logic [DW-1:0]     cpuWrData,
  input  logic [7:0]        fillTile,
  input  logic [1:0]        fillAttr,
  output logic [DW-1:0]     cpuRdData,
  output logic [DW-1:0]     ppuRdData,
  output logic              ppuDataOe
);
  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam int ATTR_REP  = DW / 2;

  logic [DW-1:0] ramMem [RAM_DEPTH];
  logic [DW-1:0] fillByte;

  always_ff @(posedge clk) begin
    if (strb.ramWr) ramMem[cpuOff] <= cpuWrData;
  end

  always_comb begin
    fillByte = strb.fillAttrRd ? {ATTR_REP{fillAttr}} : DW'(fillTile);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdData <= '0;
      ppuRdData <= '0;
      ppuDataOe <= 1'b0;
    end else begin
      cpuRdData <= strb.cpuRamRd ? ramMem[cpuOff] : '0;
      ppuDataOe <= strb.ppuOwn;
      if (strb.ppuRamRd)       ppuRdData <= ramMem[ppuOff];
      else if (strb.ppuFillRd) ppuRdData <= fillByte;
      else                     ppuRdData <= '0;
    end
  end

  // R8
  cpu_data_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdData != '0) |-> $past(strb.cpuRamRd));
  // R10
  ppu_data_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ppuRdData != '0) |-> $past(strb.ppuRamRd || strb.ppuFillRd));
endmodule

// File: rtl/nt_quad_mapper.sv
module nt_quad_mapper
  import nt_map_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  input  logic        cpuWe,
  input  logic        cpuRe,
  output logic [7:0]  cpuRdData,
  input  logic        rendering,
  input  logic [13:0] ppuAddr,
  input  logic        ppuRd,
  output logic [7:0]  ppuRdData,
  output logic        ppuDataOe,
  output logic        conNtSel,
  output logic        conNtPage
);
  ntStrobeT   strb;
  logic [7:0] fillTile;
  logic [1:0] fillAttr;

  nt_map_ctrl #(.RAM_AW(RAM_AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWe(cpuWe), .cpuRe(cpuRe), .rendering(rendering), .ppuAddr(ppuAddr),
    .ppuRd(ppuRd), .strb(strb), .conNtSel(conNtSel), .conNtPage(conNtPage),
    .fillTile(fillTile), .fillAttr(fillAttr)
  );

  nt_map_datapath #(.RAM_AW(RAM_AW), .DW(8)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cpuOff(cpuAddr[RAM_AW-1:0]), .ppuOff(ppuAddr[RAM_AW-1:0]),
    .cpuWrData(cpuWrData), .fillTile(fillTile), .fillAttr(fillAttr),
    .cpuRdData(cpuRdData), .ppuRdData(ppuRdData), .ppuDataOe(ppuDataOe)
  );
endmodule

// File: tb/nt_quad_mapper_tb.sv
module nt_quad_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuWe = 1'b0, cpuRe = 1'b0, rendering = 1'b0, ppuRd = 1'b0;
  logic [13:0] ppuAddr = '0;
  logic [7:0]  cpuRdData, ppuRdData;
  logic        ppuDataOe, conNtSel, conNtPage;

  always #4 clk = ~clk;

  nt_quad_mapper dut_i (.*);

  int checks = 0, errors = 0;
  int mMode = 0, mMap = 0, mTile = 0, mAttr = 0;
  logic [7:0] mMem [1024];
  bit   mKnown [1024];
  bit    pend = 0;
  string pendTag;
  int    eCpu, ePpu, eOe;
  bit    eCpuKnown, ePpuKnown;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic [15:0] ca, logic [7:0] wd, bit we, bit re,
                     bit rend, logic [13:0] pa, bit prd);
    bit inNt, cpuWin;
    int src, off, poff;
    @(negedge clk);
    if (pend) begin
      if (eCpuKnown) chk({pendTag, " cpuRdData"}, cpuRdData, eCpu);
      chk({pendTag, " ppuDataOe"}, ppuDataOe, eOe);
      if (ePpuKnown) chk({pendTag, " ppuRdData"}, ppuRdData, ePpu);
    end
    cpuAddr = ca; cpuWrData = wd; cpuWe = we; cpuRe = re;
    rendering = rend; ppuAddr = pa; ppuRd = prd;
    #1;
    inNt   = pa[13] && (pa[13:8] != 6'h3F);
    src    = (mMap >> (2 * int'(pa[11:10]))) & 3;
    cpuWin = (ca >= 16'h5C00);
    off    = int'(ca[9:0]);
    poff   = int'(pa[9:0]);
    chk({tag, " conNtSel"}, conNtSel, (inNt && src < 2) ? 1 : 0);
    chk({tag, " conNtPage"}, conNtPage, (inNt && src == 1) ? 1 : 0);
    // expected registered results from state before this edge
    eCpuKnown = 1; eCpu = 0;
    if (re && cpuWin && mMode >= 2) begin
      eCpuKnown = mKnown[off]; eCpu = int'(mMem[off]);
    end
    eOe = (prd && inNt && src >= 2) ? 1 : 0;
    ePpuKnown = 1; ePpu = 0;
    if (eOe == 1 && src == 2 && mMode < 2) begin
      ePpuKnown = mKnown[poff]; ePpu = int'(mMem[poff]);
    end else if (eOe == 1 && src == 3) begin
      ePpu = (poff < 'h3C0) ? mTile : (mAttr & 3) * 'h55;
    end
    // model update
    if (we) begin
      case (ca)
        16'h5104: mMode = wd & 3;
        16'h5105: mMap = wd;
        16'h5106: mTile = wd;
        16'h5107: mAttr = wd & 3;
        default: ;
      endcase
      if (cpuWin && (mMode == 2 || (mMode < 2 && rend))) begin
        mMem[off] = wd; mKnown[off] = 1;
      end
    end
    pend = 1; pendTag = tag;
  endtask

  task automatic wr(string tag, logic [15:0] a, logic [7:0] d, bit rend = 0);
    cyc(tag, a, d, 1, 0, rend, 14'h0000, 0);
  endtask
  task automatic rdCpu(string tag, logic [15:0] a);
    cyc(tag, a, 8'h00, 0, 1, 0, 14'h0000, 0);
  endtask
  task automatic rdPpu(string tag, logic [13:0] a);
    cyc(tag, 16'h0000, 8'h00, 0, 0, 1, a, 1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 cpuRdData", cpuRdData, 0);
    chk("R1 ppuRdData", ppuRdData, 0);
    chk("R1 ppuDataOe", ppuDataOe, 0);
    rdPpu("R1", 14'h2000);                 // map zero -> page A
    rdPpu("R1", 14'h2C00);
    // R2: upper bits ignored, $FE -> mode 2
    wr("R2", 16'h5104, 8'hFE);
    // R7 mode 2 read/write
    wr("R7", 16'h5C00, 8'hA5);
    wr("R7", 16'h5FFF, 8'h3C);
    wr("R7", 16'h5D23, 8'h81);
    rdCpu("R7", 16'h5C00);
    rdCpu("R7", 16'h5FFF);
    rdCpu("R7", 16'h5D23);
    rdCpu("R7", 16'h5104);                 // outside window reads zero
    // R9 mode 3 read-only
    wr("R9", 16'h5104, 8'h07);
    wr("R9", 16'h5C00, 8'h11);
    rdCpu("R9", 16'h5C00);
    wr("R9", 16'h5FFF, 8'h22, 1);
    rdCpu("R9", 16'h5FFF);
    // R5 source 2 in mode 3 returns zero with enable
    wr("R5", 16'h5105, 8'hAA);
    rdPpu("R5", 14'h2000);
    // R8 mode 0: writes only while rendering, reads zero
    wr("R8", 16'h5104, 8'h00);
    wr("R8", 16'h5C10, 8'h99, 0);
    wr("R8", 16'h5C11, 8'h5A, 1);
    rdCpu("R8", 16'h5C11);
    rdPpu("R8", 14'h2010);                 // still old A5 region? offset 0x10 unknown -> skipped
    rdPpu("R8", 14'h2411);                 // rendering write landed
    rdPpu("R5", 14'h2C00);                 // A5 at offset 0
    rdPpu("R5", 14'h3BFF);                 // mirror region, offset 3FF
    // R2 mode 1 behaves like mode 0
    wr("R2", 16'h5104, 8'h01);
    rdCpu("R2", 16'h5C00);
    wr("R8", 16'h5D23, 8'h77, 1);
    rdPpu("R8", 14'h2123);
    // R11 same-cycle read and write
    cyc("R11", 16'h5C00, 8'hEE, 1, 0, 1, 14'h2000, 1);
    rdPpu("R11", 14'h2000);
    // R4 vertical arrangement via $44
    wr("R4", 16'h5105, 8'h44);
    rdPpu("R4", 14'h2000);
    rdPpu("R4", 14'h2400);
    rdPpu("R4", 14'h2800);
    rdPpu("R4", 14'h2C00);
    // R3 mixed fields $E4: 0,1,2,3
    wr("R3", 16'h5105, 8'hE4);
    wr("R3", 16'h5106, 8'h3B);
    wr("R3", 16'h5107, 8'hFE);            // attr keeps 2
    rdPpu("R3", 14'h2000);
    rdPpu("R3", 14'h2400);
    rdPpu("R3", 14'h2800);
    rdPpu("R3", 14'h2C00);
    // R6 fill tile/attribute boundary
    wr("R6", 16'h5105, 8'hFF);
    rdPpu("R6", 14'h2000);
    rdPpu("R6", 14'h27BF);
    rdPpu("R6", 14'h2BC0);
    rdPpu("R6", 14'h2FFF);
    wr("R6", 16'h5107, 8'h01);
    rdPpu("R6", 14'h23C5);
    // R10 outside nametable space
    rdPpu("R10", 14'h3F00);
    rdPpu("R10", 14'h1000);
    rdPpu("R10", 14'h0400);
    cyc("R10", 16'h0000, 8'h00, 0, 0, 0, 14'h2000, 0);  // no read strobe
    cyc("R10", 16'h0000, 8'h00, 0, 0, 0, 14'h0000, 0);  // flush
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule